// File: doc/BRIEF.md
# Transmit Flow-Control Credit Tracker

This block does the credit accounting on the application side of a packet transmitter. The transmitter shares its link with a core that also spends credits on its own traffic. The core gives out its credit limits through a time-multiplexed port. The tracker drives a 2-bit type selector, and the core returns the header-credit and data-credit limits for the selected type two cycles later. The tracker steps the selector through the posted, non-posted and completion types. It waits out the return latency after every change and then latches the limit for that type.

Consumption for each type is a running sum from two independent sources. The first is the one-cycle pulses the core raises when it spends credits itself. The second is the sends the application reports. All counters wrap modulo their width, as flow-control arithmetic requires.

For each type the block raises a permit output when a packet needing the requested header and data credits fits. A packet fits when each request is no larger than the limit minus the consumed count, taken modulo the counter width. A type half flagged as infinite always passes that half of the check. The permits stay low while the link is down, and after link-up they stay low until every type has been sampled once.

Top module: `fc_credit_tracker`

## Requirements
- R1: The selector output takes the values 0 (posted), 1 (non-posted), 2 (completion) in that order and then repeats. It holds each value for 3 cycles and never drives 3. While the link is down it rests at 0.
- R2: A limit is latched on the third rising edge after the selector takes a type. It therefore takes the core's return value as it stands 2 cycles after that selector change.
- R3: All permits are low while the link is down. After link-up they stay low until all three types have been latched, which happens at the 9th rising edge.
- R4: A type's permit is high when the header request is ≤ (header limit − header consumed) mod 256 and the data request is ≤ (data limit − data consumed) mod 4096. Data credits count 16-byte units and header credits count 20-byte units.
- R5: Core pulse bit 2t adds 1 to the header count of type t, and bit 2t+1 adds 1 to its data count (t: 0 posted, 1 non-posted, 2 completion). The result is visible after the next rising edge.
- R6: An application send adds its header and data amounts to the type given by the 2-bit type input (0 posted, 1 non-posted, 2 completion). A send with type 3 changes no count.
- R7: A core pulse and an application send to the same type in the same cycle both add to the count.
- R8: Infinite bit 2t bypasses the header check of type t, and bit 2t+1 bypasses its data check.
- R9: Taking the link down clears every consumed count to zero.
- R10: Consumed counts wrap modulo 2^width, and the available amount is computed with wrapping.
- R11: Limits are refreshed continuously. A new limit is in use within one 9-cycle sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Link is up and credit information is valid |
| type_sel_o | output | 2 | Credit type selector driven to the core |
| lim_hdr_i | input | 8 | Header credit limit returned by the core for the selected type |
| lim_dat_i | input | 12 | Data credit limit returned by the core for the selected type |
| core_pulse_i | input | 6 | One-cycle credit spend pulses from the core, one bit per type half |
| infinite_i | input | 6 | Infinite-credit flags, same bit order as the pulses |
| app_send_i | input | 1 | Application reports a send this cycle |
| app_type_i | input | 2 | Credit type of the application send |
| app_hdr_i | input | 8 | Header credits spent by the send |
| app_dat_i | input | 12 | Data credits spent by the send |
| req_hdr_i | input | 8 | Header credits needed by the candidate packet |
| req_dat_i | input | 12 | Data credits needed by the candidate packet |
| permit_o | output | 3 | Per-type permit: bit 0 posted, bit 1 non-posted, bit 2 completion |

## Verification
The selector advances on every third rising edge after link-up. Each limit becomes usable from the edge that latches it, the 3rd, 6th and 9th edges for the three types, so the bench counts edges from the falling edge on which it raises the link. Pulses and sends reach the counts at the next rising edge, and the bench checks them at the following falling edge. The permit is combinational from the request inputs, so each boundary probe changes the request and samples one time unit later in the same low phase. The bench checks every boundary both at the available amount and at one above it.

// File: rtl/fc_pkg.sv
// Package: shared constants and the credit type encoding of the tracker.
// Assumes three credit types, each with a header half and a data half.
package fc_pkg;
    localparam int N_TYPES = 3;
    localparam int SEL_W   = 2;

    typedef enum logic [SEL_W-1:0] {
        CT_POSTED     = 2'd0,
        CT_NONPOSTED  = 2'd1,
        CT_COMPLETION = 2'd2
    } ctype_e;
endpackage

// File: rtl/fc_sampler.sv
// Module: walks the type selector and latches returned credit limits.
// Assumes the core answers a selector change after a fixed latency of
// SETTLE cycles. The selector holds each type for SETTLE+1 cycles, and the
// value is latched on the last of them. All state restarts when the link drops.
module fc_sampler #(
    parameter int HW     = 8,
    parameter int DW     = 12,
    parameter int NT     = 3,
    parameter int SW     = 2,
    parameter int SETTLE = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   link_up,
    output logic [SW-1:0]          sel_o,
    input  logic [HW-1:0]          hdr_in,
    input  logic [DW-1:0]          dat_in,
    output logic [NT-1:0][HW-1:0]  hdr_lim,
    output logic [NT-1:0][DW-1:0]  dat_lim,
    output logic [NT-1:0]          seen
);
    localparam int          CW   = $clog2(SETTLE + 1);
    localparam [SW-1:0]     LAST = SW'(NT - 1);

    logic [CW-1:0] settle_q;
    logic          take;

    assign take = link_up && (settle_q == CW'(SETTLE));

    // Selector and settle counter: wait out the return latency, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_up) begin
            sel_o    <= '0;
            settle_q <= '0;
        end else if (take) begin
            settle_q <= '0;
            sel_o    <= (sel_o == LAST) ? '0 : sel_o + 1'b1;
        end else begin
            settle_q <= settle_q + 1'b1;
        end
    end

    for (genvar g = 0; g < NT; g++) begin : g_type
        logic [HW-1:0] h_q;
        logic [DW-1:0] d_q;
        logic          s_q;
        logic          hit;

        assign hit = take && (sel_o == SW'(g));

        // Limit registers of this type: load when its sample slot ends.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                h_q <= '0;
                d_q <= '0;
            end else if (hit) begin
                h_q <= hdr_in;
                d_q <= dat_in;
            end
        end

        // Sampled flag of this type: set once latched, cleared on link loss.
        always_ff @(posedge clk) begin
            if (!rst_n || !link_up) s_q <= 1'b0;
            else if (hit)           s_q <= 1'b1;
        end

        assign hdr_lim[g] = h_q;
        assign dat_lim[g] = d_q;
        assign seen[g]    = s_q;
    end
endmodule

// File: rtl/fc_consume.sv
// Module: per-type consumed-credit counters fed by two sources.
// Assumes core pulse bit 2t marks a header credit and bit 2t+1 a data
// credit of type t. Application sends carry explicit amounts. The counters
// wrap, and they clear while the link is down.
module fc_consume #(
    parameter int HW = 8,
    parameter int DW = 12,
    parameter int NT = 3,
    parameter int SW = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   link_up,
    input  logic [2*NT-1:0]        core_pulse,
    input  logic                   app_send,
    input  logic [SW-1:0]          app_type,
    input  logic [HW-1:0]          app_hdr,
    input  logic [DW-1:0]          app_dat,
    output logic [NT-1:0][HW-1:0]  hdr_used,
    output logic [NT-1:0][DW-1:0]  dat_used
);
    for (genvar g = 0; g < NT; g++) begin : g_type
        logic [HW-1:0] h_q;
        logic [DW-1:0] d_q;
        logic          hit;

        assign hit = app_send && (app_type == SW'(g));

        // Accumulate core pulses and application sends for this type.
        always_ff @(posedge clk) begin
            if (!rst_n || !link_up) begin
                h_q <= '0;
                d_q <= '0;
            end else begin
                h_q <= h_q + HW'(core_pulse[2*g])   + (hit ? app_hdr : '0);
                d_q <= d_q + DW'(core_pulse[2*g+1]) + (hit ? app_dat : '0);
            end
        end

        assign hdr_used[g] = h_q;
        assign dat_used[g] = d_q;
    end
endmodule

// File: rtl/fc_permit.sv
// Module: combinational per-type send decision.
// Assumes limits and counts are modular. The available amount is the
// wrapped difference. Permits need the link and a full set of samples.
module fc_permit #(
    parameter int HW = 8,
    parameter int DW = 12,
    parameter int NT = 3
) (
    input  logic                   link_up,
    input  logic [NT-1:0]          seen,
    input  logic [NT-1:0][HW-1:0]  hdr_lim,
    input  logic [NT-1:0][DW-1:0]  dat_lim,
    input  logic [NT-1:0][HW-1:0]  hdr_used,
    input  logic [NT-1:0][DW-1:0]  dat_used,
    input  logic [2*NT-1:0]        infinite,
    input  logic [HW-1:0]          req_hdr,
    input  logic [DW-1:0]          req_dat,
    output logic [NT-1:0]          permit
);
    logic ready;
    assign ready = link_up && (&seen);

    for (genvar g = 0; g < NT; g++) begin : g_type
        logic [HW-1:0] avail_h;
        logic [DW-1:0] avail_d;
        logic          ok_h;
        logic          ok_d;

        // Wrapped availability and per-half checks with infinite bypass.
        assign avail_h   = hdr_lim[g] - hdr_used[g];
        assign avail_d   = dat_lim[g] - dat_used[g];
        assign ok_h      = infinite[2*g]   || (req_hdr <= avail_h);
        assign ok_d      = infinite[2*g+1] || (req_dat <= avail_d);
        assign permit[g] = ready && ok_h && ok_d;
    end
endmodule

// File: rtl/fc_credit_tracker.sv
// Module: top of the transmit credit tracker.
// Assumes the core returns the selected type's limits 2 cycles after the
// selector changes, and that its spend pulses exclude application traffic.
module fc_credit_tracker
    import fc_pkg::*;
#(
    parameter int HDR_W  = 8,
    parameter int DAT_W  = 12,
    parameter int SETTLE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               link_up,
    output logic [SEL_W-1:0]   type_sel_o,
    input  logic [HDR_W-1:0]   lim_hdr_i,
    input  logic [DAT_W-1:0]   lim_dat_i,
    input  logic [2*N_TYPES-1:0] core_pulse_i,
    input  logic [2*N_TYPES-1:0] infinite_i,
    input  logic               app_send_i,
    input  logic [SEL_W-1:0]   app_type_i,
    input  logic [HDR_W-1:0]   app_hdr_i,
    input  logic [DAT_W-1:0]   app_dat_i,
    input  logic [HDR_W-1:0]   req_hdr_i,
    input  logic [DAT_W-1:0]   req_dat_i,
    output logic [N_TYPES-1:0] permit_o
);
    logic [N_TYPES-1:0][HDR_W-1:0] hdr_lim;
    logic [N_TYPES-1:0][DAT_W-1:0] dat_lim;
    logic [N_TYPES-1:0][HDR_W-1:0] hdr_used;
    logic [N_TYPES-1:0][DAT_W-1:0] dat_used;
    logic [N_TYPES-1:0]            seen;

    fc_sampler #(.HW(HDR_W), .DW(DAT_W), .NT(N_TYPES), .SW(SEL_W), .SETTLE(SETTLE)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_up (link_up),
        .sel_o   (type_sel_o),
        .hdr_in  (lim_hdr_i),
        .dat_in  (lim_dat_i),
        .hdr_lim (hdr_lim),
        .dat_lim (dat_lim),
        .seen    (seen)
    );

    fc_consume #(.HW(HDR_W), .DW(DAT_W), .NT(N_TYPES), .SW(SEL_W)) u_consume (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_up    (link_up),
        .core_pulse (core_pulse_i),
        .app_send   (app_send_i),
        .app_type   (app_type_i),
        .app_hdr    (app_hdr_i),
        .app_dat    (app_dat_i),
        .hdr_used   (hdr_used),
        .dat_used   (dat_used)
    );

    fc_permit #(.HW(HDR_W), .DW(DAT_W), .NT(N_TYPES)) u_permit (
        .link_up  (link_up),
        .seen     (seen),
        .hdr_lim  (hdr_lim),
        .dat_lim  (dat_lim),
        .hdr_used (hdr_used),
        .dat_used (dat_used),
        .infinite (infinite_i),
        .req_hdr  (req_hdr_i),
        .req_dat  (req_dat_i),
        .permit   (permit_o)
    );
endmodule

// File: rtl/fc_credit_checker.sv
// Module: assertion checker bound into the credit tracker.
// Assumes visibility of the tracker's count and sampled-flag state.
module fc_credit_checker #(
    parameter int HW = 8,
    parameter int DW = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               link_up,
    input logic [1:0]         sel_o,
    input logic [5:0]         core_pulse,
    input logic [5:0]         infinite,
    input logic               app_send,
    input logic [1:0]         app_type,
    input logic [2:0]         permit,
    input logic [2:0][HW-1:0] hdr_used,
    input logic [2:0][DW-1:0] dat_used,
    input logic [2:0]         seen
);
    // R1: the selector never names a type that does not exist
    p_sel_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o != 2'd3);

    // R1: after a selector change the next cycle holds the value
    p_sel_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o != $past(sel_o)) |=> $stable(sel_o));

    // R3: no permit while the link is down
    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |-> (permit == 3'b000));

    // R3: no permit in the cycle after link-up
    p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |=> (permit == 3'b000));

    // R5: a lone posted-header pulse adds exactly one
    p_core_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && core_pulse[0] && !(app_send && app_type == 2'd0))
        |=> (hdr_used[0] == HW'($past(hdr_used[0]) + 1'b1)));

    // R8: both halves infinite means permit once sampling is complete
    p_inf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && (&seen) && infinite[1] && infinite[0]) |-> permit[0]);

    // R9: link loss clears all counts
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> ((hdr_used == '0) && (dat_used == '0)));
endmodule

bind fc_credit_tracker fc_credit_checker #(.HW(HDR_W), .DW(DAT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_up    (link_up),
    .sel_o      (type_sel_o),
    .core_pulse (core_pulse_i),
    .infinite   (infinite_i),
    .app_send   (app_send_i),
    .app_type   (app_type_i),
    .permit     (permit_o),
    .hdr_used   (hdr_used),
    .dat_used   (dat_used),
    .seen       (seen)
);

// File: tb/tb_fc_credit_tracker.sv
// Bench: directed scenarios against a modelled core with a 2-cycle return.
module tb_fc_credit_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b0;
    logic [1:0]  type_sel_o;
    logic [7:0]  lim_hdr_i;
    logic [11:0] lim_dat_i;
    logic [5:0]  core_pulse_i = '0;
    logic [5:0]  infinite_i = '0;
    logic        app_send_i = 1'b0;
    logic [1:0]  app_type_i = '0;
    logic [7:0]  app_hdr_i = '0;
    logic [11:0] app_dat_i = '0;
    logic [7:0]  req_hdr_i = '0;
    logic [11:0] req_dat_i = '0;
    logic [2:0]  permit_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0]  lh [3];
    logic [11:0] ld [3];
    logic [7:0]  eh [3];
    logic [11:0] ed [3];
    logic [1:0]  p1 = '0;
    logic [1:0]  p2 = '0;

    always #10 clk = ~clk;

    // Core model: the limit return lags the selector by two registers.
    always @(posedge clk) begin
        p1 <= type_sel_o;
        p2 <= p1;
    end
    assign lim_hdr_i = (p2 < 2'd3) ? lh[p2] : 8'd0;
    assign lim_dat_i = (p2 < 2'd3) ? ld[p2] : 12'd0;

    fc_credit_tracker dut (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .type_sel_o(type_sel_o),
        .lim_hdr_i(lim_hdr_i), .lim_dat_i(lim_dat_i), .core_pulse_i(core_pulse_i),
        .infinite_i(infinite_i), .app_send_i(app_send_i), .app_type_i(app_type_i),
        .app_hdr_i(app_hdr_i), .app_dat_i(app_dat_i), .req_hdr_i(req_hdr_i),
        .req_dat_i(req_dat_i), .permit_o(permit_o)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Probe the permit of type t at its header and data boundaries.
    task automatic chk_avail(int t, string tag);
        logic [7:0]  ah;
        logic [11:0] ad;
        ah = lh[t] - eh[t];
        ad = ld[t] - ed[t];
        req_hdr_i = ah; req_dat_i = ad; #1;
        chk({tag, " fits"}, int'(permit_o[t]), 1);
        if (ah != 8'hFF) begin
            req_hdr_i = ah + 8'd1; #1;
            chk({tag, " hdr over"}, int'(permit_o[t]), 0);
            req_hdr_i = ah;
        end
        if (ad != 12'hFFF) begin
            req_dat_i = ad + 12'd1; #1;
            chk({tag, " dat over"}, int'(permit_o[t]), 0);
        end
        req_hdr_i = '0; req_dat_i = '0; #1;
    endtask

    task automatic t_reset();
        repeat (3) step();
        chk("R3 reset permit", int'(permit_o), 0);
        chk("R1 reset selector", int'(type_sel_o), 0);
        rst_n = 1'b1;
        repeat (2) step();
        chk("R1 idle selector", int'(type_sel_o), 0);
    endtask

    task automatic t_linkup();
        link_up = 1'b1;
        chk("R1 selector k0", int'(type_sel_o), 0);
        for (int k = 1; k <= 12; k++) begin
            step();
            chk("R1 selector sweep", int'(type_sel_o), (k / 3) % 3);
            chk("R3 permit after link-up", int'(permit_o), (k < 9) ? 0 : 7);
        end
        chk_avail(0, "R2 R4 posted");
        chk_avail(1, "R2 R4 nonposted");
        chk_avail(2, "R2 R4 completion");
    endtask

    task automatic t_core_pulses();
        for (int b = 0; b < 6; b++) begin
            core_pulse_i = 6'(1 << b);
            step();
            core_pulse_i = '0;
            if (b % 2 == 0) eh[b/2] = eh[b/2] + 8'd1;
            else            ed[b/2] = ed[b/2] + 12'd1;
            chk_avail(b / 2, "R5 core pulse");
        end
    endtask

    task automatic t_app();
        app_send_i = 1'b1; app_type_i = 2'd1; app_hdr_i = 8'd2; app_dat_i = 12'd5;
        step();
        app_send_i = 1'b0;
        eh[1] = eh[1] + 8'd2; ed[1] = ed[1] + 12'd5;
        chk_avail(1, "R6 app send");
        app_send_i = 1'b1; app_type_i = 2'd3; app_hdr_i = 8'd7; app_dat_i = 12'd9;
        step();
        app_send_i = 1'b0;
        for (int t = 0; t < 3; t++) chk_avail(t, "R6 type 3 ignored");
    endtask

    task automatic t_both();
        core_pulse_i = 6'b000011;
        app_send_i = 1'b1; app_type_i = 2'd0; app_hdr_i = 8'd3; app_dat_i = 12'd10;
        step();
        core_pulse_i = '0; app_send_i = 1'b0;
        eh[0] = eh[0] + 8'd4; ed[0] = ed[0] + 12'd11;
        chk_avail(0, "R7 both sources");
    endtask

    task automatic t_infinite();
        req_hdr_i = 8'hFF; req_dat_i = '0; #1;
        chk("R8 hdr finite blocks", int'(permit_o[0]), 0);
        infinite_i = 6'b000001; #1;
        chk("R8 hdr infinite passes", int'(permit_o[0]), 1);
        req_hdr_i = '0; req_dat_i = 12'hFFF; infinite_i = 6'b000010; #1;
        chk("R8 dat infinite passes", int'(permit_o[0]), 1);
        infinite_i = 6'b000000; #1;
        chk("R8 dat finite blocks", int'(permit_o[0]), 0);
        req_dat_i = '0; #1;
    endtask

    task automatic t_wrap();
        app_send_i = 1'b1; app_type_i = 2'd2; app_hdr_i = 8'd250; app_dat_i = 12'd4000;
        step();
        app_send_i = 1'b0;
        eh[2] = eh[2] + 8'd250; ed[2] = ed[2] + 12'd4000;
        lh[2] = eh[2] + 8'd10;
        ld[2] = ed[2] + 12'd30;
        repeat (12) step();
        chk_avail(2, "R10 R11 wrapped limit");
    endtask

    task automatic t_linkdown();
        link_up = 1'b0; #1;
        chk("R3 link down permit", int'(permit_o), 0);
        step();
        chk("R1 selector rests", int'(type_sel_o), 0);
        link_up = 1'b1;
        repeat (8) step();
        chk("R3 resampling permit", int'(permit_o), 0);
        step();
        for (int t = 0; t < 3; t++) begin
            eh[t] = '0; ed[t] = '0;
            chk_avail(t, "R9 counts cleared");
        end
    endtask

    initial begin
        lh[0] = 8'd20; ld[0] = 12'd100;
        lh[1] = 8'd30; ld[1] = 12'd8;
        lh[2] = 8'd40; ld[2] = 12'd200;
        for (int t = 0; t < 3; t++) begin eh[t] = '0; ed[t] = '0; end
        @(negedge clk);
        t_reset();
        t_linkup();
        t_core_pulses();
        t_app();
        t_both();
        t_infinite();
        t_wrap();
        t_linkdown();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule